// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns the digital results of a supply monitor into the reset and protection signals a processor subsystem needs. It receives three comparator decisions (supply above the reset threshold, supply above the backup battery, power-fail sense input above its reference), a watchdog timeout request and a slow timebase tick. It drives an active-low reset, its active-high complement, a low-line flag, a gated chip-enable for battery-backed memory, a power-fail warning and a flag that shows the output rail is fed from the battery.

Reset falls at once when the supply becomes invalid. It is released only after a hold time counted in timebase ticks once the supply is valid again. A watchdog request starts the same hold from the running state. While the supply is below the battery, every output takes a fixed backup level and the chip-enable and power-fail inputs are ignored. The sequencer is a four-state machine:
- BACKUP: the supply is below the battery.
- LOW: above the battery but below the threshold.
- HOLD: the hold count is running.
- RUN: reset is released.

Its transitions:
- enter_backup: any state goes to BACKUP when the supply drops below the battery.
- drop_low: any state goes to LOW when the supply is above the battery but below the threshold.
- recover: BACKUP or LOW goes to HOLD when both supply conditions are good.
- hold_restart: HOLD stays in HOLD with a cleared count on a watchdog request.
- release: HOLD goes to RUN on the last tick of the hold.
- wd_bite: RUN goes to HOLD on a watchdog request.

Top module: `supv_reset_seq`

## Requirements
- R1: When the synchronised supply-above-threshold input is 0, reset (`rst_n_o`) is 0. The output follows three rising clock edges after the input falls, and no hold delays the assertion.
- R2: When the supply-above-battery input is 0, the block is in backup. Three edges after that input falls, `rst_n_o`=0, `lowline_n_o`=0, `ce_n_o`=1, `pfail_n_o`=0 and `on_bat_o`=1. Changes on `ce_n_i` and `pf_ok_i` have no effect while backup lasts.
- R3: Once both supply inputs are 1 (synchronised), reset stays 0 for a hold of HOLD_SHORT (default 512) ticks, or HOLD_LONG (2048) ticks when HOLD_SEL=1. Only clock cycles with `tick`=1 count. Reset rises on the edge that samples the last tick, which is HOLD+3 edges after the inputs rise when `tick` is held at 1.
- R4: A `wd_req_i` pulse sampled while reset is released drives `rst_n_o` to 0 on that same edge. Reset then stays 0 for one full hold. A request during the hold restarts the count.
- R5: If the supply drops below the threshold during the hold, the count is discarded, and a full hold starts again after the supply recovers.
- R6: `lowline_n_o` equals the supply-above-threshold input (AND supply-above-battery), delayed by three edges. No hold applies, and watchdog requests do not affect it.
- R7: `rst_o` is always the complement of `rst_n_o`.
- R8: While the supply is valid (both supply inputs 1), `ce_n_o` equals `ce_n_i` one edge later. Otherwise `ce_n_o` is 1.
- R9: Outside backup, `pfail_n_o` equals `pf_ok_i` three edges later. In backup it is 0.
- R10: `on_bat_o` is the inverse of the supply-above-battery input, three edges later.
- R11: While `arst_n` is 0, the outputs are `rst_n_o`=0, `rst_o`=1, `lowline_n_o`=0, `ce_n_o`=1, `pfail_n_o`=0 and `on_bat_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Timebase tick, one clock wide, counts the hold |
| sup_ok_i | input | 1 | Comparator: supply above reset threshold (asynchronous) |
| sup_gt_bat_i | input | 1 | Comparator: supply above battery (asynchronous) |
| pf_ok_i | input | 1 | Comparator: power-fail sense above reference (asynchronous) |
| wd_req_i | input | 1 | Watchdog timeout request, synchronous pulse |
| ce_n_i | input | 1 | Chip-enable to be gated, active low |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| lowline_n_o | output | 1 | Low-line flag, low while supply invalid |
| ce_n_o | output | 1 | Gated chip-enable, forced high when supply invalid |
| pfail_n_o | output | 1 | Power-fail warning, active low |
| on_bat_o | output | 1 | High while the rail runs from the battery |

## Verification
Comparator inputs pass two synchroniser flops and the output register, so their effects are due on the third rising edge. The bench checks each one after two edges (old value) and after three (new value). The chip-enable path and the watchdog request have a single register, so they are checked one edge after the stimulus. Hold release is checked one edge before and exactly at HOLD+3 edges. Where the tick is paused or the supply browns out, the expected release edge is shifted by the bench's own count. Every input is driven on the falling clock edge, and outputs are sampled on the next falling edge after the counted rising edges.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_BACKUP = 2'd0,
        ST_LOW    = 2'd1,
        ST_HOLD   = 2'd2,
        ST_RUN    = 2'd3
    } supv_state_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic meta_q;
            logic safe_q;

            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    meta_q <= 1'b0;
                    safe_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    safe_q <= meta_q;
                end
            end

            assign sync_o[g] = safe_q;
        end
    endgenerate

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = tick_i && (cnt_q == LAST) && !clr_i;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (clr_i || done_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: ticks advance the count by exactly one
    p_tick_step_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr_i && tick_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: cycles without a tick leave the count alone
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr_i && !tick_i) |=> $stable(cnt_q));

    // R5: a clear request empties the count
    p_clear_r5: assert property (@(posedge clk) disable iff (!arst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/supv_seq_fsm.sv
module supv_seq_fsm
    import supv_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic ok_s_i,
    input  logic bat_s_i,
    input  logic pf_s_i,
    input  logic wd_i,
    input  logic ce_n_i,
    input  logic hold_done_i,
    output logic hold_clr_o,
    output logic rst_n_o,
    output logic rst_o,
    output logic lowline_n_o,
    output logic ce_n_o,
    output logic pfail_n_o,
    output logic on_bat_o
);

    supv_state_t st_q;
    supv_state_t st_d;
    logic        restart;
    logic        valid;

    assign valid = ok_s_i && bat_s_i;

    // next-state logic
    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (!bat_s_i) begin
            st_d = ST_BACKUP;                     // enter_backup
        end else if (!ok_s_i) begin
            st_d = ST_LOW;                        // drop_low
        end else begin
            unique case (st_q)
                ST_BACKUP, ST_LOW: st_d = ST_HOLD; // recover
                ST_HOLD: begin
                    if (wd_i) begin
                        restart = 1'b1;           // hold_restart
                    end else if (hold_done_i) begin
                        st_d = ST_RUN;            // release
                    end
                end
                ST_RUN: begin
                    if (wd_i) begin
                        st_d = ST_HOLD;           // wd_bite
                    end
                end
            endcase
        end
    end

    assign hold_clr_o = (st_q != ST_HOLD) || restart || !valid;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= ST_BACKUP;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_n_o     <= 1'b0;
            rst_o       <= 1'b1;
            lowline_n_o <= 1'b0;
            ce_n_o      <= 1'b1;
            pfail_n_o   <= 1'b0;
            on_bat_o    <= 1'b1;
        end else begin
            rst_n_o     <= (st_d == ST_RUN);
            rst_o       <= (st_d != ST_RUN);
            lowline_n_o <= valid;
            ce_n_o      <= valid ? ce_n_i : 1'b1;
            pfail_n_o   <= bat_s_i ? pf_s_i : 1'b0;
            on_bat_o    <= !bat_s_i;
        end
    end

    // R2: loss of the battery margin always ends in BACKUP
    p_bat_first_r2: assert property (@(posedge clk) disable iff (!arst_n)
        !bat_s_i |=> (st_q == ST_BACKUP));

    // R4: watchdog request while running starts the hold
    p_wd_restart_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q == ST_RUN && wd_i && valid) |=> (st_q == ST_HOLD && !rst_n_o));

    // R3: RUN is only reached from HOLD
    p_run_entry_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q != ST_RUN && st_q != ST_HOLD) |=> (st_q != ST_RUN));

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
    parameter int HOLD_SHORT = 512,
    parameter int HOLD_LONG  = 2048,
    parameter int HOLD_SEL   = 0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic sup_ok_i,
    input  logic sup_gt_bat_i,
    input  logic pf_ok_i,
    input  logic wd_req_i,
    input  logic ce_n_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic lowline_n_o,
    output logic ce_n_o,
    output logic pfail_n_o,
    output logic on_bat_o
);

    localparam int HOLD_TICKS = (HOLD_SEL != 0) ? HOLD_LONG : HOLD_SHORT;
    localparam int N_CMP      = 3;

    logic [N_CMP-1:0] cmp_raw;
    logic [N_CMP-1:0] cmp_s;
    logic             hold_clr;
    logic             hold_done;

    assign cmp_raw = {pf_ok_i, sup_gt_bat_i, sup_ok_i};

    supv_sync #(.WIDTH(N_CMP)) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .async_i (cmp_raw),
        .sync_o  (cmp_s)
    );

    supv_hold_timer #(.LEN(HOLD_TICKS)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .clr_i  (hold_clr),
        .tick_i (tick),
        .done_o (hold_done)
    );

    supv_seq_fsm u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .ok_s_i      (cmp_s[0]),
        .bat_s_i     (cmp_s[1]),
        .pf_s_i      (cmp_s[2]),
        .wd_i        (wd_req_i),
        .ce_n_i      (ce_n_i),
        .hold_done_i (hold_done),
        .hold_clr_o  (hold_clr),
        .rst_n_o     (rst_n_o),
        .rst_o       (rst_o),
        .lowline_n_o (lowline_n_o),
        .ce_n_o      (ce_n_o),
        .pfail_n_o   (pfail_n_o),
        .on_bat_o    (on_bat_o)
    );

    // R7: the two reset polarities never agree
    p_rst_cmpl_r7: assert property (@(posedge clk) disable iff (!arst_n)
        rst_o == !rst_n_o);

    // R1: low line implies reset is asserted
    p_lowline_rst_r1: assert property (@(posedge clk) disable iff (!arst_n)
        !lowline_n_o |-> !rst_n_o);

    // R8: invalid supply blocks the chip-enable
    p_ce_forced_r8: assert property (@(posedge clk) disable iff (!arst_n)
        !lowline_n_o |-> ce_n_o);

    // R9: battery operation forces the warning
    p_pf_backup_r9: assert property (@(posedge clk) disable iff (!arst_n)
        on_bat_o |-> !pfail_n_o);

endmodule

// File: tb/sim_supv_reset_seq.sv
`timescale 1ns/1ps
module sim_supv_reset_seq;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic tick = 1'b0;
    logic sup_ok = 1'b0;
    logic sup_gt_bat = 1'b0;
    logic pf_ok = 1'b0;
    logic wd_req = 1'b0;
    logic ce_n = 1'b1;
    logic rst_n_o, rst_o, lowline_n_o, ce_n_o, pfail_n_o, on_bat_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    supv_reset_seq u0 (
        .clk          (clk),
        .arst_n       (arst_n),
        .tick         (tick),
        .sup_ok_i     (sup_ok),
        .sup_gt_bat_i (sup_gt_bat),
        .pf_ok_i      (pf_ok),
        .wd_req_i     (wd_req),
        .ce_n_i       (ce_n),
        .rst_n_o      (rst_n_o),
        .rst_o        (rst_o),
        .lowline_n_o  (lowline_n_o),
        .ce_n_o       (ce_n_o),
        .pfail_n_o    (pfail_n_o),
        .on_bat_o     (on_bat_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // from any state with valid supply: wait for release
    task automatic to_run();
        sup_ok = 1'b1; sup_gt_bat = 1'b1; pf_ok = 1'b1; tick = 1'b1;
        adv(520);
        chk("R3 running", rst_n_o, 1'b1);
    endtask

    task automatic t_reset();
        chk("R11 rst_n", rst_n_o, 1'b0);
        chk("R11 rst", rst_o, 1'b1);
        chk("R11 lowline", lowline_n_o, 1'b0);
        chk("R11 ce", ce_n_o, 1'b1);
        chk("R11 pfail", pfail_n_o, 1'b0);
        chk("R11 on_bat", on_bat_o, 1'b1);
    endtask

    task automatic t_powerup_tick_gate();
        sup_ok = 1'b1; sup_gt_bat = 1'b1; pf_ok = 1'b1; tick = 1'b1;
        adv(2);
        chk("R6 lowline not yet", lowline_n_o, 1'b0);
        chk("R10 on_bat not yet", on_bat_o, 1'b1);
        adv(1);
        chk("R6 lowline up", lowline_n_o, 1'b1);
        chk("R10 on_bat low", on_bat_o, 1'b0);
        chk("R9 pfail follows", pfail_n_o, 1'b1);
        chk("R3 rst held", rst_n_o, 1'b0);
        adv(100);
        tick = 1'b0;
        adv(300);
        chk("R3 paused tick keeps reset", rst_n_o, 1'b0);
        tick = 1'b1;
        adv(411);
        chk("R3 one tick before release", rst_n_o, 1'b0);
        chk("R7 complement low", rst_o, 1'b1);
        adv(1);
        chk("R3 released", rst_n_o, 1'b1);
        chk("R7 complement high", rst_o, 1'b0);
    endtask

    task automatic t_plain_hold();
        sup_ok = 1'b0;
        adv(2);
        chk("R1 not yet", rst_n_o, 1'b1);
        adv(1);
        chk("R1 immediate assert", rst_n_o, 1'b0);
        chk("R6 lowline low", lowline_n_o, 1'b0);
        sup_ok = 1'b1;
        adv(514);
        chk("R3 edge HOLD+2", rst_n_o, 1'b0);
        adv(1);
        chk("R3 edge HOLD+3", rst_n_o, 1'b1);
    endtask

    task automatic t_brownout();
        sup_ok = 1'b0;
        adv(3);
        sup_ok = 1'b1;
        adv(3);
        adv(200);
        sup_ok = 1'b0;
        adv(3);
        chk("R5 brownout reset", rst_n_o, 1'b0);
        chk("R5 brownout lowline", lowline_n_o, 1'b0);
        sup_ok = 1'b1;
        adv(3);
        adv(511);
        chk("R5 full hold restarted", rst_n_o, 1'b0);
        adv(1);
        chk("R5 release after full hold", rst_n_o, 1'b1);
    endtask

    task automatic t_watchdog();
        wd_req = 1'b1;
        @(posedge clk); @(negedge clk);
        wd_req = 1'b0;
        chk("R4 reset on request", rst_n_o, 1'b0);
        chk("R6 lowline unaffected", lowline_n_o, 1'b1);
        adv(200);
        wd_req = 1'b1;
        @(posedge clk); @(negedge clk);
        wd_req = 1'b0;
        adv(511);
        chk("R4 restarted hold still low", rst_n_o, 1'b0);
        adv(1);
        chk("R4 release", rst_n_o, 1'b1);
    endtask

    task automatic t_ce();
        ce_n = 1'b0;
        adv(1);
        chk("R8 follow low", ce_n_o, 1'b0);
        ce_n = 1'b1;
        adv(1);
        chk("R8 follow high", ce_n_o, 1'b1);
        ce_n = 1'b0;
        sup_ok = 1'b0;
        adv(3);
        chk("R8 forced on low supply", ce_n_o, 1'b1);
        to_run();
        chk("R8 follow after recovery", ce_n_o, 1'b0);
    endtask

    task automatic t_pf();
        pf_ok = 1'b0;
        adv(2);
        chk("R9 not yet", pfail_n_o, 1'b1);
        adv(1);
        chk("R9 warning", pfail_n_o, 1'b0);
        pf_ok = 1'b1;
        adv(3);
        chk("R9 clear", pfail_n_o, 1'b1);
    endtask

    task automatic t_backup();
        ce_n = 1'b0;
        sup_gt_bat = 1'b0;
        adv(2);
        chk("R10 not yet", on_bat_o, 1'b0);
        adv(1);
        chk("R2 on_bat", on_bat_o, 1'b1);
        chk("R2 reset", rst_n_o, 1'b0);
        chk("R2 lowline", lowline_n_o, 1'b0);
        chk("R2 ce forced", ce_n_o, 1'b1);
        chk("R2 pfail forced", pfail_n_o, 1'b0);
        pf_ok = 1'b1; ce_n = 1'b1;
        adv(2);
        ce_n = 1'b0;
        adv(4);
        chk("R2 ce ignored", ce_n_o, 1'b1);
        chk("R2 pf ignored", pfail_n_o, 1'b0);
        sup_gt_bat = 1'b1;
        adv(3);
        chk("R10 back on supply", on_bat_o, 1'b0);
        chk("R9 pfail restored", pfail_n_o, 1'b1);
        chk("R8 ce follows again", ce_n_o, 1'b0);
        chk("R3 hold after backup", rst_n_o, 1'b0);
        adv(512);
        chk("R3 release after backup", rst_n_o, 1'b1);
    endtask

    initial begin
        adv(3);
        t_reset();
        arst_n = 1'b1;
        adv(2);
        t_powerup_tick_gate();
        t_plain_hold();
        t_brownout();
        t_watchdog();
        t_ce();
        t_pf();
        t_backup();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule